// File: doc/BRIEF.md
# Packed Compare, Min/Max and Average ALU

This block is a 64-bit SIMD arithmetic unit that treats its two operands as packed vectors of byte, halfword or word lanes and applies one lane-wise operation per issued request. The operations are equality and greater-than compares, which produce all-ones or all-zero lane masks; signed and unsigned minimum and maximum; wrapping add and subtract; and truncating or rounding average. No carry or borrow ever crosses a lane boundary.

Next to the vector result the block forms a 32-bit status word. The 32 bits are split into one group per lane: 4 bits per byte lane, 8 per halfword lane and 16 per word lane. Each group holds that lane's negative and zero flags. The datapath is combinational and is followed by one register stage. The register stage loads only in cycles where the request strobe is high and holds its contents otherwise.

Top module: `simd_cmp_alu`

## Requirements
- R1: Opcodes 0 (equal), 1 (signed greater-than, operand A against B) and 2 (unsigned greater-than) write all-ones into a lane when the condition holds for that lane and all-zeros when it does not.
- R2: Opcodes 3 (signed min), 4 (unsigned min), 5 (signed max) and 6 (unsigned max) copy each lane from whichever of A or B the comparison selects.
- R3: Opcode 7 computes A+B and opcode 8 computes A-B. Both are taken modulo the lane width, with no carry or borrow between lanes.
- R4: Opcode 9 gives floor((A+B)/2) per lane and opcode 10 gives floor((A+B+1)/2), both computed without losing the carry. With the word lane size these opcodes give a zero result and a zero status word.
- R5: Lane size code 0 means byte lanes with 4-bit groups, code 1 means halfword lanes with 8-bit groups and code 2 means word lanes with 16-bit groups. Lane i owns the group that starts at bit i*group_width. The negative flag is the top bit of the group and the zero flag is the bit just below it. All other status bits read zero.
- R6: A lane's negative flag equals the top bit of its result lane. Its zero flag is set exactly when every bit of the result lane is zero.
- R7: The average opcodes set only zero flags. All negative flags stay clear.
- R8: Lane size code 3 and opcodes 11 to 15 produce a zero result and a zero status word.
- R9: When in_valid is high at a rising clock edge, res_q and flags_q show that request's result after the edge, and res_valid_q is high. When in_valid is low, res_q and flags_q keep their values and res_valid_q is low.
- R10: While rst_n is low, res_q, flags_q and res_valid_q are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; also the load enable of the output stage |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane size code |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| res_valid_q | output | 1 | A result was loaded at the last edge |
| res_q | output | 64 | Registered vector result |
| flags_q | output | 32 | Registered per-lane status word |

## Verification
Every result and status word is due one rising edge after the edge at which in_valid was high, and res_valid_q rises on that same edge. The bench changes its inputs on falling edges and compares the outputs on the next falling edge, which is half a period after the loading edge. This way no check races the register update. The hold behaviour is checked by lowering in_valid, changing the operands, and confirming on the following falling edge that res_q and flags_q still hold the previous expected values.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  localparam logic [3:0] OP_EQ    = 4'd0;
  localparam logic [3:0] OP_GTS   = 4'd1;
  localparam logic [3:0] OP_GTU   = 4'd2;
  localparam logic [3:0] OP_MINS  = 4'd3;
  localparam logic [3:0] OP_MINU  = 4'd4;
  localparam logic [3:0] OP_MAXS  = 4'd5;
  localparam logic [3:0] OP_MAXU  = 4'd6;
  localparam logic [3:0] OP_ADD   = 4'd7;
  localparam logic [3:0] OP_SUB   = 4'd8;
  localparam logic [3:0] OP_AVG_T = 4'd9;
  localparam logic [3:0] OP_AVG_R = 4'd10;

  localparam logic [1:0] LS_BYTE = 2'd0;
  localparam logic [1:0] LS_HALF = 2'd1;
  localparam logic [1:0] LS_WORD = 2'd2;
  localparam logic [1:0] LS_NONE = 2'd3;

  localparam int NUM_SIZES = 3;

  function automatic logic op_legal(input logic [3:0] code);
    return code <= OP_AVG_R;
  endfunction

  function automatic logic op_is_avg(input logic [3:0] code);
    return (code == OP_AVG_T) || (code == OP_AVG_R);
  endfunction

  function automatic logic op_is_cmp(input logic [3:0] code);
    return code <= OP_GTU;
  endfunction

  // Whole request supported: legal opcode, real lane size, no word average.
  function automatic logic req_supported(input logic [3:0] code, input logic [1:0] lsz);
    return op_legal(code) && (lsz != LS_NONE) && !(op_is_avg(code) && (lsz == LS_WORD));
  endfunction

endpackage

// File: rtl/simd_lane_ops.sv
module simd_lane_ops
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter bit AVG_OK = 1'b1
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int NLANE = DATA_W / LANE_W;

  logic rnd;
  assign rnd = (op == OP_AVG_R);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb, lr, avg_v;
    logic              eq_c, gtu_c, gts_c;

    assign la    = a[i*LANE_W +: LANE_W];
    assign lb    = b[i*LANE_W +: LANE_W];
    assign eq_c  = (la == lb);
    assign gtu_c = (la > lb);
    assign gts_c = ($signed(la) > $signed(lb));

    if (AVG_OK) begin : g_avg
      // floor((a+b+r)/2) kept inside LANE_W bits: halves plus majority of LSBs
      logic carry_lsb;
      assign carry_lsb = (la[0] & lb[0]) | (rnd & (la[0] | lb[0]));
      assign avg_v = {1'b0, la[LANE_W-1:1]} + {1'b0, lb[LANE_W-1:1]} +
                     {{(LANE_W-1){1'b0}}, carry_lsb};
    end else begin : g_noavg
      assign avg_v = '0;
    end

    always_comb begin
      unique case (op)
        OP_EQ:    lr = eq_c  ? '1 : '0;
        OP_GTS:   lr = gts_c ? '1 : '0;
        OP_GTU:   lr = gtu_c ? '1 : '0;
        OP_MINS:  lr = gts_c ? lb : la;
        OP_MINU:  lr = gtu_c ? lb : la;
        OP_MAXS:  lr = gts_c ? la : lb;
        OP_MAXU:  lr = gtu_c ? la : lb;
        OP_ADD:   lr = la + lb;
        OP_SUB:   lr = la - lb;
        OP_AVG_T,
        OP_AVG_R: lr = avg_v;
        default:  lr = '0;
      endcase
    end

    assign y[i*LANE_W +: LANE_W] = lr;
  end

endmodule

// File: rtl/simd_flag_pack.sv
module simd_flag_pack
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   y,
  input  logic [1:0]          lsz,
  input  logic                zonly,
  output logic [DATA_W/2-1:0] flags
);

  localparam int FLAG_W = DATA_W / 2;

  logic [NUM_SIZES-1:0][FLAG_W-1:0] cand;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
    localparam int LW = 8 << k;
    localparam int NL = DATA_W / LW;
    localparam int GW = LW / 2;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      logic [LW-1:0] v;
      assign v = y[i*LW +: LW];
      assign cand[k][i*GW +: GW] = {v[LW-1] & ~zonly, ~|v, {(GW-2){1'b0}}};
    end
  end

  always_comb begin
    unique case (lsz)
      LS_BYTE: flags = cand[0];
      LS_HALF: flags = cand[1];
      LS_WORD: flags = cand[2];
      default: flags = '0;
    endcase
  end

endmodule

// File: rtl/simd_cmp_alu.sv
module simd_cmp_alu
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0]          op,
  input  logic [1:0]          lane_sz,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  output logic                res_valid_q,
  output logic [DATA_W-1:0]   res_q,
  output logic [DATA_W/2-1:0] flags_q
);

  localparam int FLAG_W = DATA_W / 2;

  logic [NUM_SIZES-1:0][DATA_W-1:0] y_sz;
  logic [DATA_W-1:0] y_sel, res_d, res_nxt;
  logic [FLAG_W-1:0] flag_pre, flags_d, flags_nxt;
  logic              sup, avg_op, vld_nxt;

  // One lane-parallel datapath per lane size; only byte and halfword average.
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_ops
    simd_lane_ops #(
      .DATA_W (DATA_W),
      .LANE_W (8 << k),
      .AVG_OK (k < 2)
    ) u_ops (
      .op (op),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (y_sz[k])
    );
  end

  always_comb begin
    avg_op = op_is_avg(op);
    sup    = req_supported(op, lane_sz);
    unique case (lane_sz)
      LS_BYTE: y_sel = y_sz[0];
      LS_HALF: y_sel = y_sz[1];
      LS_WORD: y_sel = y_sz[2];
      default: y_sel = '0;
    endcase
    res_d = sup ? y_sel : '0;
  end

  simd_flag_pack #(.DATA_W(DATA_W)) u_flags (
    .y     (res_d),
    .lsz   (lane_sz),
    .zonly (avg_op),
    .flags (flag_pre)
  );

  assign flags_d = sup ? flag_pre : '0;

  // Next state: load on request, otherwise hold.
  always_comb begin
    res_nxt   = res_q;
    flags_nxt = flags_q;
    vld_nxt   = in_valid;
    if (in_valid) begin
      res_nxt   = res_d;
      flags_nxt = flags_d;
    end
  end

  // rst_n is expected already deasserted synchronously by the reset tree.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q       <= '0;
      flags_q     <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_q       <= res_nxt;
      flags_q     <= flags_nxt;
      res_valid_q <= vld_nxt;
    end
  end

endmodule

// File: rtl/simd_cmp_alu_chk.sv
module simd_cmp_alu_chk
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [3:0]          op,
  input logic [1:0]          lane_sz,
  input logic                res_valid_q,
  input logic [DATA_W-1:0]   res_q,
  input logic [DATA_W/2-1:0] flags_q
);

  localparam int FLAG_W = DATA_W / 2;

  logic [3:0] cap_op;
  logic [1:0] cap_ls;
  logic       cap_sup, cap_avg, cap_cmp;
  logic [3:0] cmp_ok, z_ok;
  logic [NUM_SIZES-1:0][FLAG_W-1:0] nz_mask, n_mask;
  logic [FLAG_W-1:0] nz_sel, n_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op <= '0;
      cap_ls <= '0;
    end else if (in_valid) begin
      cap_op <= op;
      cap_ls <= lane_sz;
    end
  end

  assign cap_sup = req_supported(cap_op, cap_ls);
  assign cap_avg = op_is_avg(cap_op);
  assign cap_cmp = op_is_cmp(cap_op);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
    localparam int LW = 8 << k;
    localparam int NL = DATA_W / LW;
    localparam int GW = LW / 2;
    logic [NL-1:0] lane_mask_ok, lane_z_ok;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      logic [LW-1:0] v;
      assign v = res_q[i*LW +: LW];
      assign lane_mask_ok[i] = (&v) || (~|v);
      assign lane_z_ok[i]    = flags_q[i*GW + GW - 2] == (~|v);
      assign nz_mask[k][i*GW +: GW] = {2'b11, {(GW-2){1'b0}}};
      assign n_mask[k][i*GW +: GW]  = {1'b1, {(GW-1){1'b0}}};
    end
    assign cmp_ok[k] = &lane_mask_ok;
    assign z_ok[k]   = &lane_z_ok;
  end
  assign cmp_ok[3] = 1'b1;
  assign z_ok[3]   = 1'b1;

  always_comb begin
    unique case (cap_ls)
      LS_BYTE: begin nz_sel = nz_mask[0]; n_sel = n_mask[0]; end
      LS_HALF: begin nz_sel = nz_mask[1]; n_sel = n_mask[1]; end
      LS_WORD: begin nz_sel = nz_mask[2]; n_sel = n_mask[2]; end
      default: begin nz_sel = '0;         n_sel = '0;         end
    endcase
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid_q); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid_q && $stable(res_q) && $stable(flags_q))); // R9

  AST_CMP_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_q && cap_cmp) |-> cmp_ok[cap_ls]); // R1

  AST_AVG_NEG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_q && cap_avg) |-> ((flags_q & n_sel) == '0)); // R7

  AST_SPARE_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~nz_sel) == '0); // R5

  AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_q && cap_sup) |-> z_ok[cap_ls]); // R6

  AST_UNSUPPORTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_q && !cap_sup) |-> (res_q == '0 && flags_q == '0)); // R8

endmodule

bind simd_cmp_alu simd_cmp_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op          (op),
  .lane_sz     (lane_sz),
  .res_valid_q (res_valid_q),
  .res_q       (res_q),
  .flags_q     (flags_q)
);

// File: tb/simd_cmp_alu_bench.sv
`timescale 1ns/1ps
module simd_cmp_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  lane_sz;
  logic [63:0] opnd_a, opnd_b;
  logic        res_valid_q;
  logic [63:0] res_q;
  logic [31:0] flags_q;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [63:0] last_r;
  logic [31:0] last_f;

  always #2.5 clk = ~clk;

  simd_cmp_alu u_simd_cmp_alu (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op          (op),
    .lane_sz     (lane_sz),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .res_valid_q (res_valid_q),
    .res_q       (res_q),
    .flags_q     (flags_q)
  );

  // Reference computed from the requirements with plain integer arithmetic.
  function automatic void ref_calc(input logic [3:0] c, input logic [1:0] ls,
                                   input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] r, output logic [31:0] f);
    int lw, nl, gw;
    logic [63:0] m, sb, x, y, z;
    r = '0;
    f = '0;
    if (ls == 2'd3 || c > 4'd10 || (ls == 2'd2 && c >= 4'd9)) return;
    lw = 8 << ls;
    nl = 64 / lw;
    gw = lw / 2;
    m  = (64'd1 << lw) - 64'd1;
    sb = 64'd1 << (lw - 1);
    for (int i = 0; i < nl; i++) begin
      x = (a >> (i * lw)) & m;
      y = (b >> (i * lw)) & m;
      case (c)
        4'd0:    z = (x == y) ? m : '0;
        4'd1:    z = ((x ^ sb) > (y ^ sb)) ? m : '0;
        4'd2:    z = (x > y) ? m : '0;
        4'd3:    z = ((x ^ sb) < (y ^ sb)) ? x : y;
        4'd4:    z = (x < y) ? x : y;
        4'd5:    z = ((x ^ sb) > (y ^ sb)) ? x : y;
        4'd6:    z = (x > y) ? x : y;
        4'd7:    z = (x + y) & m;
        4'd8:    z = (x - y) & m;
        4'd9:    z = (x + y) >> 1;
        default: z = (x + y + 64'd1) >> 1;
      endcase
      r = r | (z << (i * lw));
      if (c < 4'd9 && z[lw-1]) f = f | (32'd1 << (i * gw + gw - 1));
      if (z == '0)             f = f | (32'd1 << (i * gw + gw - 2));
    end
  endfunction

  function automatic string req_of(input logic [3:0] c, input logic [1:0] ls);
    if (ls == 2'd3 || c > 4'd10) return "R8";
    if (c <= 4'd2) return "R1";
    if (c <= 4'd6) return "R2";
    if (c <= 4'd8) return "R3";
    return "R4";
  endfunction

  function automatic logic [63:0] corner(input int k, input int lw);
    logic [63:0] m, sb;
    m  = (64'd1 << lw) - 64'd1;
    sb = 64'd1 << (lw - 1);
    case (k)
      0:       return '0;
      1:       return 64'd1;
      2:       return sb - 64'd1;
      3:       return sb;
      4:       return m;
      5:       return m - 64'd1;
      6:       return 64'h5555_5555_5555_5555 & m;
      default: return sb + 64'd1;
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [3:0] c, input logic [1:0] ls,
                         input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic [31:0] ef;
    @(negedge clk);
    in_valid = 1'b1;
    op       = c;
    lane_sz  = ls;
    opnd_a   = a;
    opnd_b   = b;
    ref_calc(c, ls, a, b, er, ef);
    @(negedge clk);
    check64({req_of(c, ls), " result"}, res_q, er);
    check64({"R5 R6 R7 flags ", req_of(c, ls)}, {32'd0, flags_q}, {32'd0, ef});
    check64("R9 valid", {63'd0, res_valid_q}, 64'd1);
    last_r = er;
    last_f = ef;
  endtask

  initial begin
    logic [63:0] a, b;
    int lw, nl;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op       = '0;
    lane_sz  = '0;
    opnd_a   = '0;
    opnd_b   = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    opnd_a   = 64'h1234_5678_9abc_def0;
    @(negedge clk);
    // R10: reset holds everything at zero even with a request pending
    check64("R10 reset result", res_q, '0);
    check64("R10 reset flags", {32'd0, flags_q}, '0);
    check64("R10 reset valid", {63'd0, res_valid_q}, '0);
    in_valid = 1'b0;
    rst_n    = 1'b1;

    // Corner sweep: every opcode, every lane-size code, 8x8 corner pairs
    for (int c = 0; c < 16; c++) begin
      for (int ls = 0; ls < 4; ls++) begin
        lw = (ls == 3) ? 8 : (8 << ls);
        nl = 64 / lw;
        for (int ia = 0; ia < 8; ia++) begin
          for (int ib = 0; ib < 8; ib++) begin
            a = '0;
            b = '0;
            for (int i = 0; i < nl; i++) begin
              a = a | (corner((ia + i) % 8, lw) << (i * lw));
              b = b | (corner((ib + 3 * i) % 8, lw) << (i * lw));
            end
            run_vec(4'(c), 2'(ls), a, b);
          end
        end
      end
    end

    // R3: carry and borrow must not cross lanes
    run_vec(4'd7, 2'd0, 64'hff00_ff00_ff00_ff00, 64'h0100_0100_0100_0100);
    run_vec(4'd8, 2'd1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
    // R4: average of maxima keeps its carry
    run_vec(4'd10, 2'd1, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffe);

    // Random patterns, with idle cycles that must hold the outputs (R9)
    for (int n = 0; n < 1500; n++) begin
      run_vec(4'($urandom_range(0, 11)), 2'($urandom_range(0, 3)),
              {$urandom, $urandom}, {$urandom, $urandom});
      if (n % 10 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        op       = 4'($urandom_range(0, 10));
        opnd_a   = {$urandom, $urandom};
        opnd_b   = ~opnd_a;
        @(negedge clk);
        check64("R9 hold result", res_q, last_r);
        check64("R9 hold flags", {32'd0, flags_q}, {32'd0, last_f});
        check64("R9 idle valid", {63'd0, res_valid_q}, '0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule